// File: doc/BRIEF.md
# Set-Associative I/O Translation Lookaside Buffer

This block translates the I/O virtual addresses that a device issues into physical addresses. It holds a 128-set, 16-way table of 4 KB page translations. Every entry is tagged with a 9-bit address space number, so several devices can keep overlapping virtual ranges in the table at once. A lookup that finds no matching entry is never refilled by the block. It becomes a no-mapping fault, and software installs the translation and retries the access.

Software owns the table through two independent maintenance paths. One path installs or invalidates a chosen set and way. The other reads any entry back at any time. Faults fall into three classes: missing translation, permission violation, and corrupted entry (parity). Faults are handled in stall mode. The oldest fault is presented and the request port stops accepting work. Faults already in flight queue behind the presented one, and each clear pulse from software advances to the next. Every fault carries a destination mask taken from a per-address-space routing table, and the mask drives a bank of interrupt lines.

Top module: `iommu_tlb`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid, flt_pending and flt_overflow are 0, irq_cause and irq_dest are all zero, and every entry reads back as invalid.
- R2: A lookup hits when a valid entry in set iova[18:12] has an ASN equal to req_asn and a tag equal to iova[31:19]. A hit returns rsp_fault=0 and rsp_pa={ppn, iova[11:0]}. Entries in different ways of one set translate independently.
- R3: A lookup that hits no entry (wrong ASN, wrong tag or invalid entry) returns rsp_fault=1 and rsp_pa=0, and presents fault class 1 (no mapping). It is never refilled.
- R4: rsp_valid is asserted for one cycle, on the second rising edge after the edge that accepted the request. Back-to-back requests are answered back to back.
- R5: A hit whose permission bit for the access is clear (read needs R, write needs W) faults with class 2 (protection).
- R6: A hit on an entry with bad parity faults with class 3 (parity), whatever its permissions. irq_cause is one-hot for the presented fault: bit 0 no mapping, bit 1 protection, bit 2 parity.
- R7: While a fault is presented, req_ready is 0. Faults from requests already in flight queue and are presented in arrival order, one per flt_clear pulse. req_ready returns to 1 once the queue is empty.
- R8: An invalidate command (mw_install=0) clears only the valid bit of the named set and way. Later lookups to that entry miss.
- R9: A maintenance read returns mr_entry = {valid, asn[8:0], tag[12:0], ppn[19:0], r, w, parity} on the first rising edge after the command edge. A write to another location on the same edge does not disturb it.
- R10: irq_dest carries the routing-table mask of the presented fault's ASN, captured when that request was looked up. It is zero when no fault is pending.
- R11: A fault that arrives while the queue is full is dropped and sets flt_overflow, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_iova | input | 32 | I/O virtual address |
| req_asn | input | 9 | Address space number of the request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_pa | output | 32 | Physical address (0 on fault) |
| mw_valid | input | 1 | Maintenance write command |
| mw_install | input | 1 | 1 = install entry, 0 = invalidate |
| mw_set | input | 7 | Target set |
| mw_way | input | 4 | Target way |
| mw_asn | input | 9 | ASN of new entry |
| mw_tag | input | 13 | Virtual tag of new entry |
| mw_ppn | input | 20 | Physical page number of new entry |
| mw_perm_r | input | 1 | Read permitted |
| mw_perm_w | input | 1 | Write permitted |
| mw_corrupt | input | 1 | Store inverted parity (error injection) |
| mr_valid | input | 1 | Maintenance read command |
| mr_set | input | 7 | Set to read |
| mr_way | input | 4 | Way to read |
| mr_rvalid | output | 1 | Read-back data valid |
| mr_entry | output | 46 | Read-back entry |
| rt_we | input | 1 | Routing table write |
| rt_asn | input | 9 | Routing table index |
| rt_mask | input | 15 | Destination mask to store |
| flt_pending | output | 1 | A fault is presented |
| flt_class | output | 2 | Presented fault class (1, 2, 3) |
| flt_iova | output | 32 | Address of presented fault |
| flt_asn | output | 9 | ASN of presented fault |
| flt_clear | input | 1 | Retire presented fault |
| flt_overflow | output | 1 | Sticky fault queue overflow |
| irq_cause | output | 3 | One-hot cause of presented fault |
| irq_dest | output | 15 | Interrupt lines per destination |

## Verification
A corrupted valid bit or tag in one way shows up as a wrong translation or a false miss on the very next lookup of that set, two edges after acceptance. A maintenance read-back of the same entry exposes it one edge after the command. Wrong fault-queue pointers show up as faults presented out of order, a repeated or skipped address after a clear, or req_ready staying low once the queue should be empty. A wrongly captured routing mask is seen on irq_dest as soon as the fault is presented, in the same cycle as the faulting response.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_MISS   = 2'd1,
    FLT_PROT   = 2'd2,
    FLT_PARITY = 2'd3
  } flt_class_e;
endpackage

// File: rtl/iotlb_way_bank.sv
// One way of the TLB: payload in RAM, valid bits in resettable flops.
module iotlb_way_bank #(
  parameter int DEPTH = 128,
  parameter int W     = 45
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mem_we,
  input  logic                     vld_we,
  input  logic                     vld_wdata,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] lk_addr,
  output logic                     lk_vld,
  output logic [W-1:0]             lk_data,
  input  logic [$clog2(DEPTH)-1:0] mr_addr,
  output logic                     mr_vld,
  output logic [W-1:0]             mr_data
);
  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (mem_we) mem[waddr] <= wdata;
    lk_data <= mem[lk_addr];
    mr_data <= mem[mr_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      lk_vld <= 1'b0;
      mr_vld <= 1'b0;
    end else begin
      if (vld_we) vld[waddr] <= vld_wdata;
      lk_vld <= vld[lk_addr];
      mr_vld <= vld[mr_addr];
    end
  end
endmodule

// File: rtl/iotlb_route_table.sv
// ASN-indexed destination mask table, synchronous read.
module iotlb_route_table #(
  parameter int ASN_W = 9,
  parameter int DESTS = 15
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ASN_W-1:0] waddr,
  input  logic [DESTS-1:0] wdata,
  input  logic [ASN_W-1:0] raddr,
  output logic [DESTS-1:0] rdata
);
  localparam int DEPTH = 1 << ASN_W;
  logic [DESTS-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/iotlb_fault_fifo.sv
// Fault record queue with sticky overflow.
module iotlb_fault_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 58
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         head_valid,
  output logic [W-1:0] head,
  output logic         overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_pop, do_push, full;

  assign full       = (cnt == CW'(DEPTH));
  assign do_pop     = pop && (cnt != '0);
  assign do_push    = push && (!full || do_pop);
  assign head_valid = (cnt != '0);
  assign head       = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
      if (push && !do_push) overflow <= 1'b1;
    end
  end

  p_count_bound_r11: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

// File: rtl/iommu_tlb.sv
module iommu_tlb #(
  parameter int IOVA_W    = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_W    = 12,
  parameter int SETS      = 128,
  parameter int WAYS      = 16,
  parameter int ASN_W     = 9,
  parameter int DESTS     = 15,
  parameter int FLT_DEPTH = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = IOVA_W - PAGE_W - SET_W,
  localparam int PPN_W = PA_W - PAGE_W,
  localparam int PAY_W = ASN_W + TAG_W + PPN_W + 3,
  localparam int ENT_W = PAY_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IOVA_W-1:0] req_iova,
  input  logic [ASN_W-1:0]  req_asn,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_pa,
  input  logic              mw_valid,
  input  logic              mw_install,
  input  logic [SET_W-1:0]  mw_set,
  input  logic [WAY_W-1:0]  mw_way,
  input  logic [ASN_W-1:0]  mw_asn,
  input  logic [TAG_W-1:0]  mw_tag,
  input  logic [PPN_W-1:0]  mw_ppn,
  input  logic              mw_perm_r,
  input  logic              mw_perm_w,
  input  logic              mw_corrupt,
  input  logic              mr_valid,
  input  logic [SET_W-1:0]  mr_set,
  input  logic [WAY_W-1:0]  mr_way,
  output logic              mr_rvalid,
  output logic [ENT_W-1:0]  mr_entry,
  input  logic              rt_we,
  input  logic [ASN_W-1:0]  rt_asn,
  input  logic [DESTS-1:0]  rt_mask,
  output logic              flt_pending,
  output logic [1:0]        flt_class,
  output logic [IOVA_W-1:0] flt_iova,
  output logic [ASN_W-1:0]  flt_asn,
  input  logic              flt_clear,
  output logic              flt_overflow,
  output logic [2:0]        irq_cause,
  output logic [DESTS-1:0]  irq_dest
);
  import iotlb_pkg::*;

  localparam int REC_W = 2 + IOVA_W + ASN_W + DESTS;

  // payload layout: {asn, tag, ppn, r, w, parity}
  logic [PAY_W-1:0] wr_pay;
  logic [PAY_W-2:0] wr_body;
  assign wr_body = {mw_asn, mw_tag, mw_ppn, mw_perm_r, mw_perm_w};
  assign wr_pay  = {wr_body, (^wr_body) ^ mw_corrupt};

  logic             acc;
  logic [SET_W-1:0] lk_set;
  assign acc    = req_valid && req_ready;
  assign lk_set = req_iova[PAGE_W +: SET_W];

  logic [WAYS-1:0]  lk_vld, mr_vld;
  logic [PAY_W-1:0] lk_pay [WAYS];
  logic [PAY_W-1:0] mr_pay [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic sel_w;
    assign sel_w = mw_valid && (mw_way == WAY_W'(w));
    iotlb_way_bank #(.DEPTH(SETS), .W(PAY_W)) bank_i (
      .clk(clk), .rst(rst),
      .mem_we(sel_w && mw_install), .vld_we(sel_w), .vld_wdata(mw_install),
      .waddr(mw_set), .wdata(wr_pay),
      .lk_addr(lk_set), .lk_vld(lk_vld[w]), .lk_data(lk_pay[w]),
      .mr_addr(mr_set), .mr_vld(mr_vld[w]), .mr_data(mr_pay[w])
    );
  end

  logic [DESTS-1:0] rt_rdata;
  iotlb_route_table #(.ASN_W(ASN_W), .DESTS(DESTS)) route_i (
    .clk(clk), .we(rt_we), .waddr(rt_asn), .wdata(rt_mask),
    .raddr(req_asn), .rdata(rt_rdata)
  );

  // stage 1: RAM read in flight
  logic              s1_v, s1_wr;
  logic [IOVA_W-1:0] s1_iova;
  logic [ASN_W-1:0]  s1_asn;
  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= acc;
    s1_iova <= req_iova;
    s1_asn  <= req_asn;
    s1_wr   <= req_write;
  end

  // tag/ASN compare across all ways, lowest matching way wins
  logic             hit;
  logic [PAY_W-1:0] hit_pay;
  always_comb begin
    hit     = 1'b0;
    hit_pay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lk_vld[w] && lk_pay[w][PAY_W-1 -: ASN_W] == s1_asn &&
          lk_pay[w][PAY_W-1-ASN_W -: TAG_W] == s1_iova[IOVA_W-1 -: TAG_W]) begin
        hit     = 1'b1;
        hit_pay = lk_pay[w];
      end
    end
  end

  // stage 2: selected entry
  logic              s2_v, s2_hit, s2_wr;
  logic [PAY_W-1:0]  s2_pay;
  logic [IOVA_W-1:0] s2_iova;
  logic [ASN_W-1:0]  s2_asn;
  logic [DESTS-1:0]  s2_mask;
  always_ff @(posedge clk) begin
    if (rst) s2_v <= 1'b0;
    else     s2_v <= s1_v;
    s2_hit  <= hit;
    s2_pay  <= hit_pay;
    s2_iova <= s1_iova;
    s2_asn  <= s1_asn;
    s2_wr   <= s1_wr;
    s2_mask <= rt_rdata;
  end

  // stage 3: parity and permission, classify
  flt_class_e cls;
  logic       perm_ok;
  assign perm_ok = s2_wr ? s2_pay[1] : s2_pay[2];
  always_comb begin
    if (!s2_hit)      cls = FLT_MISS;
    else if (^s2_pay) cls = FLT_PARITY;
    else if (!perm_ok) cls = FLT_PROT;
    else              cls = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= s2_v;
      rsp_fault <= s2_v && (cls != FLT_NONE);
      rsp_pa    <= (cls == FLT_NONE) ? {s2_pay[3 +: PPN_W], s2_iova[PAGE_W-1:0]} : '0;
    end
  end

  logic [REC_W-1:0] rec_head;
  iotlb_fault_fifo #(.DEPTH(FLT_DEPTH), .W(REC_W)) fifo_i (
    .clk(clk), .rst(rst),
    .push(s2_v && (cls != FLT_NONE)),
    .din({cls, s2_iova, s2_asn, s2_mask}),
    .pop(flt_clear),
    .head_valid(flt_pending), .head(rec_head), .overflow(flt_overflow)
  );

  assign req_ready = !flt_pending;
  assign flt_class = flt_pending ? rec_head[REC_W-1 -: 2] : 2'd0;
  assign flt_iova  = rec_head[REC_W-3 -: IOVA_W];
  assign flt_asn   = rec_head[DESTS +: ASN_W];
  assign irq_dest  = flt_pending ? rec_head[DESTS-1:0] : '0;
  assign irq_cause = {flt_class == FLT_PARITY, flt_class == FLT_PROT, flt_class == FLT_MISS};

  // maintenance read: RAM edge, then way select edge
  logic             mr_q;
  logic [WAY_W-1:0] mr_way_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      mr_q      <= 1'b0;
      mr_rvalid <= 1'b0;
      mr_entry  <= '0;
    end else begin
      mr_q      <= mr_valid;
      mr_rvalid <= mr_q;
      if (mr_q) mr_entry <= {mr_vld[mr_way_q], mr_pay[mr_way_q]};
    end
    mr_way_q <= mr_way;
  end

  p_fixed_latency_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready, 3));
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    flt_pending && !flt_clear |=> flt_pending && $stable(flt_iova) && $stable(flt_asn));
  p_cause_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    flt_pending |-> $countones(irq_cause) == 1);
  p_dest_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !flt_pending |-> irq_dest == '0);
  p_fault_stops_req_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> flt_pending || flt_overflow);
endmodule

// File: tb/iommu_tlb_tb_top.sv
module iommu_tlb_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [31:0] req_iova = 0;
  logic [8:0]  req_asn = 0;
  logic        mw_valid = 0, mw_install = 0, mw_perm_r = 0, mw_perm_w = 0, mw_corrupt = 0;
  logic [6:0]  mw_set = 0, mr_set = 0;
  logic [3:0]  mw_way = 0, mr_way = 0;
  logic [8:0]  mw_asn = 0, rt_asn = 0;
  logic [12:0] mw_tag = 0;
  logic [19:0] mw_ppn = 0;
  logic        mr_valid = 0, rt_we = 0, flt_clear = 0;
  logic [14:0] rt_mask = 0;

  logic        req_ready, rsp_valid, rsp_fault, mr_rvalid, flt_pending, flt_overflow;
  logic [31:0] rsp_pa, flt_iova;
  logic [45:0] mr_entry;
  logic [1:0]  flt_class;
  logic [8:0]  flt_asn;
  logic [2:0]  irq_cause;
  logic [14:0] irq_dest;

  logic        o2_ready, o2_rv, o2_rf, o2_mrv, o2_pend, o2_ovf;
  logic [31:0] o2_pa, o2_iova;
  logic [45:0] o2_ent;
  logic [1:0]  o2_cls;
  logic [8:0]  o2_asn;
  logic [2:0]  o2_cause;
  logic [14:0] o2_dest;

  iommu_tlb dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_iova(req_iova), .req_asn(req_asn), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .mw_valid(mw_valid), .mw_install(mw_install), .mw_set(mw_set), .mw_way(mw_way),
    .mw_asn(mw_asn), .mw_tag(mw_tag), .mw_ppn(mw_ppn), .mw_perm_r(mw_perm_r),
    .mw_perm_w(mw_perm_w), .mw_corrupt(mw_corrupt),
    .mr_valid(mr_valid), .mr_set(mr_set), .mr_way(mr_way), .mr_rvalid(mr_rvalid),
    .mr_entry(mr_entry), .rt_we(rt_we), .rt_asn(rt_asn), .rt_mask(rt_mask),
    .flt_pending(flt_pending), .flt_class(flt_class), .flt_iova(flt_iova),
    .flt_asn(flt_asn), .flt_clear(flt_clear), .flt_overflow(flt_overflow),
    .irq_cause(irq_cause), .irq_dest(irq_dest)
  );

  // same stimulus, shallow fault queue, used for the overflow check
  iommu_tlb #(.FLT_DEPTH(2)) dut_ovf_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(o2_ready),
    .req_iova(req_iova), .req_asn(req_asn), .req_write(req_write),
    .rsp_valid(o2_rv), .rsp_fault(o2_rf), .rsp_pa(o2_pa),
    .mw_valid(mw_valid), .mw_install(mw_install), .mw_set(mw_set), .mw_way(mw_way),
    .mw_asn(mw_asn), .mw_tag(mw_tag), .mw_ppn(mw_ppn), .mw_perm_r(mw_perm_r),
    .mw_perm_w(mw_perm_w), .mw_corrupt(mw_corrupt),
    .mr_valid(mr_valid), .mr_set(mr_set), .mr_way(mr_way), .mr_rvalid(o2_mrv),
    .mr_entry(o2_ent), .rt_we(rt_we), .rt_asn(rt_asn), .rt_mask(rt_mask),
    .flt_pending(o2_pend), .flt_class(o2_cls), .flt_iova(o2_iova),
    .flt_asn(o2_asn), .flt_clear(flt_clear), .flt_overflow(o2_ovf),
    .irq_cause(o2_cause), .irq_dest(o2_dest)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard
  typedef struct {
    logic        fault;
    logic [31:0] pa;
    int          drv_cyc;
    string       req;
  } exp_t;
  exp_t sb[$];

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) begin
        check("R4 unexpected response", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.req, " fault"}, 64'(rsp_fault), 64'(e.fault));
        check({e.req, " pa"}, 64'(rsp_pa), 64'(e.pa));
        check("R4 latency", 64'(cyc - e.drv_cyc), 64'd3);
      end
    end
  end

  function automatic logic [6:0] set_of(input logic [31:0] a); return a[18:12]; endfunction
  function automatic logic [12:0] tag_of(input logic [31:0] a); return a[31:19]; endfunction

  task automatic issue(input logic [31:0] a, input logic [8:0] asn, input logic wr,
                       input logic f, input logic [31:0] pa, input string req);
    exp_t e;
    @(negedge clk);
    req_valid = 1; req_iova = a; req_asn = asn; req_write = wr;
    e.fault = f; e.pa = pa; e.drv_cyc = cyc; e.req = req;
    if (!req_ready) check({req, " ready before issue"}, 64'd0, 64'd1);
    @(posedge clk);
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic install(input logic [6:0] s, input logic [3:0] w, input logic [8:0] asn,
                         input logic [12:0] tag, input logic [19:0] ppn,
                         input logic r, input logic wp, input logic bad);
    @(negedge clk);
    mw_valid = 1; mw_install = 1; mw_set = s; mw_way = w; mw_asn = asn;
    mw_tag = tag; mw_ppn = ppn; mw_perm_r = r; mw_perm_w = wp; mw_corrupt = bad;
    @(negedge clk);
    mw_valid = 0; mw_corrupt = 0;
  endtask

  task automatic invalidate(input logic [6:0] s, input logic [3:0] w);
    @(negedge clk);
    mw_valid = 1; mw_install = 0; mw_set = s; mw_way = w;
    @(negedge clk);
    mw_valid = 0;
  endtask

  task automatic route(input logic [8:0] asn, input logic [14:0] m);
    @(negedge clk);
    rt_we = 1; rt_asn = asn; rt_mask = m;
    @(negedge clk);
    rt_we = 0;
  endtask

  // read-back: command at one negedge, data after the following edge
  task automatic readback(input logic [6:0] s, input logic [3:0] w,
                          input logic [45:0] exp, input string req);
    @(negedge clk);
    mr_valid = 1; mr_set = s; mr_way = w;
    @(negedge clk);
    mr_valid = 0;
    @(negedge clk);
    check({req, " rvalid"}, 64'(mr_rvalid), 64'd1);
    check({req, " entry"}, 64'(mr_entry), 64'(exp));
  endtask

  function automatic logic [45:0] ent(input logic v, input logic [8:0] asn,
                                      input logic [12:0] tag, input logic [19:0] ppn,
                                      input logic r, input logic w);
    return {v, asn, tag, ppn, r, w, ^{asn, tag, ppn, r, w}};
  endfunction

  task automatic chk_flt(input logic [1:0] cls, input logic [31:0] a, input logic [8:0] asn,
                         input logic [2:0] cause, input logic [14:0] dest, input string req);
    check({req, " pending"}, 64'(flt_pending), 64'd1);
    check({req, " ready low"}, 64'(req_ready), 64'd0);
    check({req, " class"}, 64'(flt_class), 64'(cls));
    check({req, " iova"}, 64'(flt_iova), 64'(a));
    check({req, " asn"}, 64'(flt_asn), 64'(asn));
    check({req, " cause"}, 64'(irq_cause), 64'(cause));
    check({req, " dest"}, 64'(irq_dest), 64'(dest));
  endtask

  task automatic clear_flt();
    @(negedge clk);
    flt_clear = 1;
    @(negedge clk);
    flt_clear = 0;
  endtask

  localparam logic [31:0] A  = 32'h1234_5678;
  localparam logic [31:0] B  = A ^ 32'h0010_0000;
  localparam logic [31:0] C  = 32'h0000_3abc;
  localparam logic [31:0] D1 = 32'h0040_0000;
  localparam logic [31:0] D2 = 32'h0080_1000;
  localparam logic [31:0] D3 = 32'h00c0_2000;

  initial begin
    #(4 * 100000);
    check("watchdog expired", 64'd1, 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", 64'(req_ready), 64'd1);
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 pending", 64'(flt_pending), 64'd0);
    check("R1 cause", 64'(irq_cause), 64'd0);
    check("R1 dest", 64'(irq_dest), 64'd0);
    check("R1 overflow", 64'(flt_overflow), 64'd0);
    @(negedge clk);
    mr_valid = 1; mr_set = set_of(A); mr_way = 3;
    @(negedge clk); mr_valid = 0;
    @(negedge clk);
    check("R1 entry invalid", 64'(mr_entry[45]), 64'd0);

    route(9'd5, 15'h0011);
    route(9'd7, 15'h4002);
    install(set_of(A), 4'd3, 9'd5, tag_of(A), 20'hABCDE, 1, 1, 0);
    install(set_of(B), 4'd9, 9'd7, tag_of(B), 20'h13579, 1, 0, 0);

    // R2 hits, R4 back-to-back latency
    issue(A, 9'd5, 0, 0, 32'hABCD_E678, "R2 hit read way3");
    issue(A, 9'd5, 1, 0, 32'hABCD_E678, "R2 hit write way3");
    issue(B, 9'd7, 0, 0, 32'h1357_9678, "R2 hit read way9");
    idle(4);

    // R5 protection
    issue(B, 9'd7, 1, 1, 32'd0, "R5 write no perm");
    idle(4);
    chk_flt(2'd2, B, 9'd7, 3'b010, 15'h4002, "R5/R10");
    clear_flt();
    check("R7 ready after clear", 64'(req_ready), 64'd1);
    check("R10 dest quiet", 64'(irq_dest), 64'd0);

    // R3 misses: wrong ASN, then wrong tag for ASN
    issue(A, 9'd7, 0, 1, 32'd0, "R3 asn mismatch");
    idle(4);
    chk_flt(2'd1, A, 9'd7, 3'b001, 15'h4002, "R3");
    clear_flt();
    issue(B, 9'd5, 0, 1, 32'd0, "R3 tag mismatch");
    idle(4);
    chk_flt(2'd1, B, 9'd5, 3'b001, 15'h0011, "R3/R10");
    clear_flt();

    // R6 parity
    install(set_of(C), 4'd0, 9'd5, tag_of(C), 20'h00001, 1, 1, 1);
    issue(C, 9'd5, 0, 1, 32'd0, "R6 parity hit");
    idle(4);
    chk_flt(2'd3, C, 9'd5, 3'b100, 15'h0011, "R6");
    clear_flt();

    // R8 invalidate
    invalidate(set_of(A), 4'd3);
    issue(A, 9'd5, 0, 1, 32'd0, "R8 after invalidate");
    idle(4);
    chk_flt(2'd1, A, 9'd5, 3'b001, 15'h0011, "R8");
    clear_flt();
    readback(set_of(A), 4'd3, ent(0, 9'd5, tag_of(A), 20'hABCDE, 1, 1), "R8 readback");
    issue(B, 9'd7, 0, 0, 32'h1357_9678, "R8 other way intact");
    idle(4);

    // R9 read-back concurrent with a write elsewhere
    @(negedge clk);
    mr_valid = 1; mr_set = set_of(B); mr_way = 9;
    mw_valid = 1; mw_install = 1; mw_set = 7'd10; mw_way = 4'd1; mw_asn = 9'd3;
    mw_tag = 13'h0AA; mw_ppn = 20'h55555; mw_perm_r = 0; mw_perm_w = 1; mw_corrupt = 0;
    @(negedge clk);
    mr_valid = 0; mw_valid = 0;
    @(negedge clk);
    check("R9 rvalid", 64'(mr_rvalid), 64'd1);
    check("R9 concurrent entry", 64'(mr_entry), 64'(ent(1, 9'd7, tag_of(B), 20'h13579, 1, 0)));
    readback(7'd10, 4'd1, ent(1, 9'd3, 13'h0AA, 20'h55555, 0, 1), "R9 new entry");

    // R7 stall queue and R11 overflow
    issue(D1, 9'd5, 0, 1, 32'd0, "R7 burst 1");
    issue(D2, 9'd7, 0, 1, 32'd0, "R7 burst 2");
    issue(D3, 9'd5, 0, 1, 32'd0, "R7 burst 3");
    idle(4);
    check("R11 overflow on shallow queue", 64'(o2_ovf), 64'd1);
    check("R11 no overflow on deep queue", 64'(flt_overflow), 64'd0);
    chk_flt(2'd1, D1, 9'd5, 3'b001, 15'h0011, "R7 first");
    clear_flt();
    chk_flt(2'd1, D2, 9'd7, 3'b001, 15'h4002, "R7 second");
    clear_flt();
    chk_flt(2'd1, D3, 9'd5, 3'b001, 15'h0011, "R7 third");
    clear_flt();
    check("R7 queue empty", 64'(flt_pending), 64'd0);
    check("R7 ready restored", 64'(req_ready), 64'd1);
    check("R11 overflow sticky", 64'(o2_ovf), 64'd1);
    issue(B, 9'd7, 0, 0, 32'h1357_9678, "R2 hit after stall");
    idle(5);
    check("R4 scoreboard drained", 64'(sb.size()), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule